// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Wake and Self Refresh

This block keeps a 4096-row DRAM alive. After reset it waits out the power-up pause and then issues a fixed number of wake-up refresh cycles, owning the DRAM control pins alone. Only then does it raise `ready`. From that point a tick timer adds one owed refresh each refresh interval. The block repays the owed refreshes by asking an access controller for the pins (`ref_req`/`ref_gnt`). For each grant it drives one CAS-before-RAS sequence itself, with CAS falling first, RAS following, and WE held high.

The owed count saturates. A large count raises an urgent flag, which tells the arbiter to put refresh ahead of any pending access. A saturated count means the retention period has been exceeded. In that case `ready` is withdrawn, and the next grant re-runs the wake-up cycles.

A self-refresh request is served through the same grant. The block starts a CAS-before-RAS sequence and holds RAS low. Once the minimum self-refresh time has elapsed it raises `sr_active`. When the request is withdrawn, it holds RAS high for the exit precharge time before handing the pins back. Optionally it then books a full burst of row refreshes as owed, for systems that refresh in bursts rather than evenly.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and on the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, `ready`, `ref_req` and `sr_active` are 0, `owed` is 0 and `pin_own` is 1.
- R2: The first fall of `cas_n` occurs PWRUP_CYC clock cycles after reset is released. Until then `ras_n` and `cas_n` stay high.
- R3: After the power-up wait, exactly WAKE_N CAS-before-RAS cycles run with no grant. In the cycle `ready` rises, `pin_own` falls and `owed` is 0.
- R4: In every refresh cycle, `cas_n` is low for CSR_CYC cycles before `ras_n` falls and rises CHR_CYC cycles after `ras_n` falls. `ras_n` then stays low for RAS_CYC cycles in total and stays high for at least RP_CYC cycles before its next fall. `we_n` is never 0.
- R5: While `ready` is 1 and no self refresh is in progress, `owed` grows by exactly one every INTERVAL cycles when no refresh is being repaid.
- R6: While the pins are idle, `ref_req` is 1 whenever `owed` > 0, `sr_req` is 1, or `owed` is saturated. `ref_urgent` is 1 only when `owed` > URGENT_THR, and never without `ref_req`.
- R7: A grant while `ref_req` is 1 makes `pin_own` 1 and runs one refresh cycle that lowers `owed` by one. A grant while `ref_req` is 0 has no effect on the pins or on `pin_own`.
- R8: `owed` stops at DEBT_MAX and does not wrap. When it saturates, `ready` falls. The next grant runs WAKE_N refresh cycles, then clears `owed` and restores `ready`. A saturated count takes priority over a self-refresh request.
- R9: A grant with `sr_req` at 1 starts a CAS-before-RAS entry that keeps `ras_n` and `cas_n` low. `sr_active` rises only after `ras_n` has been low for at least RASS_CYC cycles. `owed` does not change while self refresh lasts.
- R10: Self refresh is left once `sr_active` is 1 and `sr_req` is 0. `ras_n` and `cas_n` rise, and `pin_own` falls RPS_CYC cycles later. If POST_SR_BURST is 1, `owed` equals ROWS in that same cycle; otherwise it is unchanged.
- R11: With the grant held, refreshes run back to back until `owed` reaches 0. Successive `ras_n` falls are CSR_CYC+RAS_CYC+RP_CYC+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter hands the DRAM pins to this block |
| sr_req | input | 1 | Level request to enter (1) or leave (0) self refresh |
| ref_req | output | 1 | Block wants the DRAM pins |
| ref_urgent | output | 1 | Owed count above threshold; refresh outranks accesses |
| pin_own | output | 1 | Block is driving the DRAM control pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (both byte strobes tied together) |
| we_n | output | 1 | Write enable, held high |
| ready | output | 1 | DRAM initialised; accesses allowed |
| sr_active | output | 1 | DRAM is in self refresh |
| owed | output | DEBT_W | Number of refreshes currently owed |

## Verification
A grant is accepted on the clock edge after it is seen with `ref_req` high. `cas_n` falls on that edge. `ras_n` follows CSR_CYC edges later, and the owed count drops on the edge that ends the precharge. The bench measures every strobe phase by counting clock samples between the pin edges it observes. It places each single-grant test just after a tick, so that no interval boundary falls inside the measured window. Self-refresh and saturation results are read on the same sample where `pin_own` or `ready` changes, because the owed count updates on that same edge.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    ST_PWR,   // power-up pause, pins high
    ST_IDLE,  // pins released to the access side
    ST_CSU,   // CAS low, RAS high
    ST_HOLD,  // CAS low, RAS low
    ST_RASW,  // CAS high, RAS low
    ST_PRE,   // both high, precharge
    ST_SRF,   // self refresh: both low
    ST_SRX    // self refresh exit precharge
  } seq_st_t;
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R5: ticks are single-cycle pulses separated by the interval
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
  parameter int DEBT_MAX   = 8192,
  parameter int ROWS       = 4096,
  parameter int URGENT_THR = 64,
  parameter int DW         = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          dec,
  input  logic          clr,
  input  logic          load,
  output logic [DW-1:0] owed,
  output logic          any,
  output logic          hot,
  output logic          sat
);
  localparam logic [DW-1:0] MAXV = DW'(DEBT_MAX);
  localparam logic [DW-1:0] ROWV = DW'(ROWS);
  localparam logic [DW-1:0] THRV = DW'(URGENT_THR);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed <= '0;
    end else if (load) begin
      owed <= ROWV;
    end else begin
      case ({tick, dec})
        2'b10:   if (owed != MAXV) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign any = (owed != '0);
  assign hot = (owed > THRV);
  assign sat = (owed == MAXV);

  // R8: a saturated count holds rather than wrapping
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sat && !dec && !clr && !load) |=> (owed == MAXV));
  // R7: a repaid refresh lowers the count by exactly one
  p_dec_step_r7: assert property (@(posedge clk) disable iff (rst)
    (dec && !tick && !clr && !load && any) |=> (owed == $past(owed) - 1'b1));
endmodule

// File: rtl/rfs_cbr_seq.sv
module rfs_cbr_seq
  import rfs_pkg::*;
#(
  parameter int PWRUP_CYC     = 12500,
  parameter int WAKE_N        = 8,
  parameter int CSR_CYC       = 1,
  parameter int CHR_CYC       = 1,
  parameter int RAS_CYC       = 7,
  parameter int RP_CYC        = 5,
  parameter int RASS_CYC      = 10000,
  parameter int RPS_CYC       = 14,
  parameter int POST_SR_BURST = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic owe_any,
  input  logic owe_hot,
  input  logic stale,
  input  logic sr_req,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic pin_own,
  output logic ref_req,
  output logic ref_urgent,
  output logic ready,
  output logic sr_active,
  output logic tick_en,
  output logic dec_pls,
  output logic clr_pls,
  output logic load_pls
);
  localparam int RASW_CYC = RAS_CYC - CHR_CYC;
  localparam int L1 = (PWRUP_CYC > RASS_CYC) ? PWRUP_CYC : RASS_CYC;
  localparam int L2 = (RPS_CYC > RP_CYC) ? RPS_CYC : RP_CYC;
  localparam int L3 = (RASW_CYC > CSR_CYC) ? RASW_CYC : CSR_CYC;
  localparam int L4 = (L1 > L2) ? L1 : L2;
  localparam int L5 = (L3 > CHR_CYC) ? L3 : CHR_CYC;
  localparam int LONGEST = (L4 > L5) ? L4 : L5;
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam int WK_W  = $clog2(WAKE_N + 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [WK_W-1:0]  wake_left;
  logic             waking;
  logic             sr_go;
  logic             last;
  logic             want;
  logic             start;

  always_comb begin
    case (st)
      ST_PWR:  lim = CNT_W'(PWRUP_CYC - 1);
      ST_CSU:  lim = CNT_W'(CSR_CYC - 1);
      ST_HOLD: lim = CNT_W'(CHR_CYC - 1);
      ST_RASW: lim = CNT_W'(RASW_CYC - 1);
      ST_PRE:  lim = CNT_W'(RP_CYC - 1);
      ST_SRF:  lim = CNT_W'(RASS_CYC - 1);
      ST_SRX:  lim = CNT_W'(RPS_CYC - 1);
      default: lim = '0;
    endcase
  end

  assign last     = (cnt == lim);
  assign want     = stale | sr_req | owe_any;
  assign start    = (st == ST_IDLE) && ref_req && gnt && want;
  assign dec_pls  = (st == ST_PRE) && last && !waking;
  assign clr_pls  = (st == ST_PRE) && last && waking && (wake_left == WK_W'(1));
  assign load_pls = (POST_SR_BURST != 0) && (st == ST_SRX) && last;
  assign tick_en  = ready && (st != ST_SRF) && (st != ST_SRX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_PWR;
      cnt        <= '0;
      ras_n      <= 1'b1;
      cas_n      <= 1'b1;
      we_n       <= 1'b1;
      pin_own    <= 1'b1;
      ref_req    <= 1'b0;
      ref_urgent <= 1'b0;
      ready      <= 1'b0;
      sr_active  <= 1'b0;
      wake_left  <= WK_W'(WAKE_N);
      waking     <= 1'b1;
      sr_go      <= 1'b0;
    end else begin
      we_n <= 1'b1;
      case (st)
        ST_PWR: begin
          if (last) begin
            st    <= ST_CSU;
            cnt   <= '0;
            cas_n <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CSU: begin
          if (last) begin
            st    <= ST_HOLD;
            cnt   <= '0;
            ras_n <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (last) begin
            cnt <= '0;
            if (sr_go) st <= ST_SRF;
            else begin
              st    <= ST_RASW;
              cas_n <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_RASW: begin
          if (last) begin
            st    <= ST_PRE;
            cnt   <= '0;
            ras_n <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PRE: begin
          if (last) begin
            cnt <= '0;
            if (waking && wake_left != WK_W'(1)) begin
              wake_left <= wake_left - 1'b1;
              st        <= ST_CSU;
              cas_n     <= 1'b0;
            end else begin
              if (waking) begin
                waking <= 1'b0;
                ready  <= 1'b1;
              end
              st      <= ST_IDLE;
              pin_own <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_IDLE: begin
          ref_req    <= want;
          ref_urgent <= want && owe_hot;
          if (stale) ready <= 1'b0;
          if (start) begin
            ref_req    <= 1'b0;
            ref_urgent <= 1'b0;
            pin_own    <= 1'b1;
            cas_n      <= 1'b0;
            st         <= ST_CSU;
            cnt        <= '0;
            sr_go      <= sr_req && !stale;
            if (stale) begin
              waking    <= 1'b1;
              wake_left <= WK_W'(WAKE_N);
            end
          end
        end
        ST_SRF: begin
          if (!last) cnt <= cnt + 1'b1;
          else sr_active <= 1'b1;
          if (sr_active && !sr_req) begin
            st        <= ST_SRX;
            cnt       <= '0;
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            sr_active <= 1'b0;
            sr_go     <= 1'b0;
          end
        end
        ST_SRX: begin
          if (last) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            pin_own <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: RAS never falls unless CAS is already low
  p_cas_first_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> !cas_n);
  // R7: released pins are parked high
  p_idle_pins_r7: assert property (@(posedge clk) disable iff (rst)
    !pin_own |-> (ras_n && cas_n));
  // R6: urgency only accompanies a request
  p_urgent_req_r6: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> ref_req);
  // R9: self refresh keeps both strobes low
  p_sr_low_r9: assert property (@(posedge clk) disable iff (rst)
    sr_active |-> (!ras_n && !cas_n));
  // R3: readiness arrives together with releasing the pins
  p_ready_release_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> !pin_own);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROWS          = 4096,
  parameter int INTERVAL      = 1953,
  parameter int PWRUP_CYC     = 12500,
  parameter int WAKE_N        = 8,
  parameter int CSR_CYC       = 1,
  parameter int CHR_CYC       = 1,
  parameter int RAS_CYC       = 7,
  parameter int RP_CYC        = 5,
  parameter int RASS_CYC      = 10000,
  parameter int RPS_CYC       = 14,
  parameter int DEBT_MAX      = 8192,
  parameter int URGENT_THR    = 64,
  parameter int POST_SR_BURST = 0,
  localparam int DEBT_W       = $clog2(DEBT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_gnt,
  input  logic              sr_req,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              pin_own,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ready,
  output logic              sr_active,
  output logic [DEBT_W-1:0] owed
);
  logic tick, tick_en, dec_pls, clr_pls, load_pls;
  logic owe_any, owe_hot, stale;

  rfs_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .tick(tick)
  );

  rfs_debt_ctr #(
    .DEBT_MAX(DEBT_MAX), .ROWS(ROWS), .URGENT_THR(URGENT_THR), .DW(DEBT_W)
  ) u_debt (
    .clk(clk), .rst(rst), .tick(tick), .dec(dec_pls), .clr(clr_pls),
    .load(load_pls), .owed(owed), .any(owe_any), .hot(owe_hot), .sat(stale)
  );

  rfs_cbr_seq #(
    .PWRUP_CYC(PWRUP_CYC), .WAKE_N(WAKE_N), .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .RASS_CYC(RASS_CYC), .RPS_CYC(RPS_CYC), .POST_SR_BURST(POST_SR_BURST)
  ) u_seq (
    .clk(clk), .rst(rst), .owe_any(owe_any), .owe_hot(owe_hot),
    .stale(stale), .sr_req(sr_req), .gnt(ref_gnt), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .pin_own(pin_own), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ready(ready), .sr_active(sr_active),
    .tick_en(tick_en), .dec_pls(dec_pls), .clr_pls(clr_pls),
    .load_pls(load_pls)
  );
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int ROWS = 16, INTERVAL = 20, PWRUP = 30, WAKE_N = 8;
  localparam int CSR = 1, CHR = 1, RASC = 3, RP = 2, RASS = 10, RPS = 3;
  localparam int DMAX = 32, THR = 4;
  localparam int DW = $clog2(DMAX + 1);
  localparam int PERIOD = CSR + RASC + RP + 2;

  logic clk = 1'b0, rst = 1'b1, gnt = 1'b0, sr = 1'b0;
  logic req, urg, own, ras_n, cas_n, we_n, ready, sra;
  logic [DW-1:0] owed;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_sched #(
    .ROWS(ROWS), .INTERVAL(INTERVAL), .PWRUP_CYC(PWRUP), .WAKE_N(WAKE_N),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP),
    .RASS_CYC(RASS), .RPS_CYC(RPS), .DEBT_MAX(DMAX), .URGENT_THR(THR),
    .POST_SR_BURST(1)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_gnt(gnt), .sr_req(sr), .ref_req(req),
    .ref_urgent(urg), .pin_own(own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ready(ready), .sr_active(sra), .owed(owed)
  );

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // pin monitor: counts samples between strobe edges
  logic p_ras = 1'b1, p_cas = 1'b1;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0, cbr_cnt = 0, order_bad = 0, we_bad = 0;
  int m_lead = 0, m_hold = 0, m_raslo = 0, m_rp = 0, m_period = 0, last_fall = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (we_n !== 1'b1) we_bad++;
      if (!ras_n && p_ras) begin
        if (cas_n) order_bad++;
        m_lead = cas_lo; m_rp = ras_hi; m_period = cyc - last_fall;
        last_fall = cyc; cbr_cnt++;
      end
      if (ras_n && !p_ras) m_raslo = ras_lo;
      if (cas_n && !p_cas && !ras_n) m_hold = ras_lo;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, c0, o;
    cycles(4);
    // R1 reset values
    chk(ras_n && cas_n && we_n, "R1 pins", {ras_n, cas_n, we_n}, 7);
    chk(!ready && !req && !sra && owed == 0 && own, "R1 status",
        {ready, req, sra, own}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !ready && own, "R1 after release", {ras_n, cas_n}, 3);
    // R2 power-up pause
    for (int i = 0; i < 200 && cas_n; i++) begin
      if (!ras_n) chk(0, "R2 ras early", 0, 1);
      @(negedge clk);
    end
    chk(cyc >= PWRUP && cyc <= PWRUP + 1, "R2 first cas", cyc, PWRUP);
    // R3 wake cycles without grant
    for (int i = 0; i < 500 && !ready; i++) @(negedge clk);
    chk(cbr_cnt == WAKE_N, "R3 wake count", cbr_cnt, WAKE_N);
    chk(!own && owed == 0, "R3 release", {own, 1'b0}, 0);
    chk(m_lead == CSR, "R4 cas setup", m_lead, CSR);
    chk(m_hold == CHR, "R4 cas hold", m_hold, CHR);
    chk(m_raslo == RASC, "R4 ras low", m_raslo, RASC);
    // R7 grant with no request has no effect
    gnt = 1'b1; c0 = cbr_cnt;
    cycles(5);
    chk(!own && ras_n && cas_n && cbr_cnt == c0, "R7 idle grant", own, 0);
    chk(!req, "R6 no req when nothing owed", req, 0);
    gnt = 1'b0;
    // R5 interval
    for (int i = 0; i < 100 && owed != 1; i++) @(negedge clk);
    t0 = cyc;
    for (int i = 0; i < 100 && owed != 2; i++) @(negedge clk);
    chk(cyc - t0 == INTERVAL, "R5 tick spacing", cyc - t0, INTERVAL);
    chk(req && !urg, "R6 req no urgent", {req, urg}, 2);
    // R6 urgent above threshold
    for (int i = 0; i < 300 && owed != THR + 1; i++) @(negedge clk);
    cycles(2);
    chk(urg && req, "R6 urgent", {req, urg}, 3);
    // R7 single grant, aligned just after a tick
    o = owed;
    for (int i = 0; i < 100 && owed == o; i++) @(negedge clk);
    o = owed; c0 = cbr_cnt; gnt = 1'b1;
    for (int i = 0; i < 20 && !own; i++) @(negedge clk);
    gnt = 1'b0;
    for (int i = 0; i < 20 && own; i++) @(negedge clk);
    chk(owed == o - 1, "R7 one repaid", owed, o - 1);
    chk(cbr_cnt == c0 + 1, "R7 one cycle", cbr_cnt - c0, 1);
    chk(m_lead == CSR && m_hold == CHR && m_raslo == RASC, "R4 grant timing",
        m_raslo, RASC);
    // R8 saturation
    for (int i = 0; i < 2000 && ready; i++) @(negedge clk);
    chk(owed == DMAX && !ready, "R8 saturate", owed, DMAX);
    cycles(3 * INTERVAL);
    chk(owed == DMAX && req, "R8 no wrap", owed, DMAX);
    c0 = cbr_cnt; gnt = 1'b1; sr = 1'b1;
    for (int i = 0; i < 20 && !own; i++) @(negedge clk);
    gnt = 1'b0; sr = 1'b0;
    for (int i = 0; i < 300 && !ready; i++) @(negedge clk);
    chk(cbr_cnt - c0 == WAKE_N, "R8 rewake count", cbr_cnt - c0, WAKE_N);
    chk(owed == 0 && ready && !sra, "R8 rewake clear", owed, 0);
    // R9 self refresh entry
    cycles(2);
    sr = 1'b1; gnt = 1'b1;
    for (int i = 0; i < 20 && !own; i++) @(negedge clk);
    gnt = 1'b0;
    for (int i = 0; i < 100 && !sra; i++) @(negedge clk);
    chk(sra && ras_lo >= RASS, "R9 min low time", ras_lo, RASS);
    o = owed;
    cycles(4 * INTERVAL);
    chk(owed == o && !ras_n && !cas_n && sra, "R9 frozen", owed, o);
    // R10 exit
    sr = 1'b0;
    for (int i = 0; i < 50 && own; i++) @(negedge clk);
    chk(ras_hi >= RPS && !sra, "R10 exit precharge", ras_hi, RPS);
    chk(owed == ROWS, "R10 burst booked", owed, ROWS);
    cycles(2);
    chk(urg, "R10 urgent after exit", urg, 1);
    // R11 back-to-back burst
    c0 = cbr_cnt; gnt = 1'b1;
    for (int i = 0; i < 2000 && owed != 0; i++) @(negedge clk);
    gnt = 1'b0;
    chk(owed == 0, "R11 drained", owed, 0);
    chk(cbr_cnt - c0 >= ROWS, "R11 cycle count", cbr_cnt - c0, ROWS);
    chk(m_period == PERIOD, "R11 spacing", m_period, PERIOD);
    chk(m_rp >= RP, "R4 precharge", m_rp, RP);
    chk(order_bad == 0, "R4 cas before ras", order_bad, 0);
    chk(we_bad == 0, "R4 we high", we_bad, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule